// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block performs the entry step of exception handling in a 32-bit soft CPU. Each request carries a vector of pending causes, the program counter to be saved, and the current interrupt-enable register. The block picks one cause and works out the handler address from one of two base registers and a remap control. It then emits a single redirect beat. That beat carries the new PC, a request to save the old PC into either the exception-address link or the breakpoint-address link, and the next value of the interrupt-enable register.

Both edges of the block are valid/ready streams. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The redirect beat appears on the following cycle and is held with all its fields stable until `redir_ready` is seen high. While a beat is held and `redir_ready` is low, `req_ready` is low, so no request is lost. A request whose causes are all masked still transfers but produces no beat. The fetch stage uses the beat as its flush and redirect.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Bit i of `req_pend` requests cause i, with 0 = reset, 1 = breakpoint, 2 = instruction bus error, 3 = watchpoint, 4 = data bus error, 5 = divide by zero, 6 = external interrupt, 7 = system call. When several bits are set, the lowest-numbered unmasked cause is taken.
- R2: The interrupt cause (bit 6) is ignored while `req_ie[0]` (the global enable IE) is 0.
- R3: The new PC equals the selected base plus 32 times the cause number. Breakpoint (1) and watchpoint (3) always use `dbg_base`.
- R4: Causes 0, 2, 4, 5, 6 and 7 use `dbg_base` when `dbg_remap` is 1 and `norm_base` when it is 0.
- R5: For causes 2, 4, 5, 6 and 7, the beat asserts `save_ea`, deasserts `save_ba`, and sets `save_pc` to the request PC. `ie_next` takes IE = 0 in bit 0, bit 1 (EIE) = old EIE OR old IE, and bit 2 (BIE) unchanged.
- R6: For causes 1 and 3, the beat asserts `save_ba`, deasserts `save_ea`, and sets `save_pc` to the request PC. `ie_next` takes IE = 0, bit 2 (BIE) = old BIE OR old IE, and EIE unchanged.
- R7: For the reset cause (0), neither `save_ea` nor `save_ba` is asserted, and `ie_next` is all zero.
- R8: A request accepted with at least one unmasked cause raises `redir_valid` on the next cycle. A request accepted with no unmasked cause raises nothing.
- R9: While `redir_valid` is 1 and `redir_ready` is 0, every redirect output is held stable and `req_ready` is 0.
- R10: After reset, `redir_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_pend | input | 8 | Pending cause vector, bit i = cause i |
| req_pc | input | 32 | PC to save |
| req_ie | input | 3 | Current enable register: bit0 IE, bit1 EIE, bit2 BIE |
| norm_base | input | 32 | Base address for normal causes |
| dbg_base | input | 32 | Base address for debug causes |
| dbg_remap | input | 1 | Moves normal causes onto the debug base |
| redir_valid | output | 1 | Redirect beat present |
| redir_ready | input | 1 | Fetch side takes the beat |
| redir_pc | output | 32 | Handler address |
| save_ea | output | 1 | Write save_pc into the exception-address link |
| save_ba | output | 1 | Write save_pc into the breakpoint-address link |
| save_pc | output | 32 | PC to be written into the link |
| ie_next | output | 3 | Updated enable register |

## Verification
The hardest case to reach is a masked interrupt that appears together with other causes under every combination of enable bits and remap. Only a full sweep of the pending vector against the enable register shows that the priority walk skips the masked bit instead of stopping on it. The bench therefore steps through all 256 pending patterns, all 8 enable values and both remap settings, one request per cycle with the output always accepted. A separate stalled sequence changes the request while the beat is held, and checks that nothing moves until the fetch side accepts.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int CAUSE_N = 8;
  localparam int CAUSE_W = $clog2(CAUSE_N);
  localparam int VEC_SHIFT = 5;
  localparam int IRQ_IDX = 6;

  localparam int IE_BIT  = 0;
  localparam int EIE_BIT = 1;
  localparam int BIE_BIT = 2;
  localparam int IEREG_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    C_RESET   = 3'd0,
    C_BREAK   = 3'd1,
    C_IBUS    = 3'd2,
    C_WATCH   = 3'd3,
    C_DBUS    = 3'd4,
    C_DIV0    = 3'd5,
    C_IRQ     = 3'd6,
    C_SYSCALL = 3'd7
  } cause_e;

  typedef enum logic [1:0] {
    K_RESET  = 2'd0,
    K_NORMAL = 2'd1,
    K_DEBUG  = 2'd2
  } kind_e;

  function automatic kind_e kind_of(input logic [CAUSE_W-1:0] c);
    case (cause_e'(c))
      C_RESET:          kind_of = K_RESET;
      C_BREAK, C_WATCH: kind_of = K_DEBUG;
      default:          kind_of = K_NORMAL;
    endcase
  endfunction
endpackage

// File: rtl/exc_cause_arb.sv
module exc_cause_arb #(
  parameter int N   = 8,
  parameter int IRQ = 6,
  localparam int W  = $clog2(N)
) (
  input  logic [N-1:0] pend,
  input  logic         irq_en,
  output logic         any,
  output logic [W-1:0] idx
);
  logic [N-1:0] live;
  logic [N:0]   seen;
  logic [N-1:0] grant;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    if (i == IRQ) begin : g_irq
      assign live[i] = pend[i] & irq_en;
    end else begin : g_plain
      assign live[i] = pend[i];
    end
    assign grant[i]  = live[i] & ~seen[i];
    assign seen[i+1] = seen[i] | live[i];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = idx | W'(i);
    end
  end
endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen #(
  parameter int XLEN  = 32,
  parameter int CW    = 3,
  parameter int SHIFT = 5
) (
  input  logic [CW-1:0]   cause,
  input  logic            is_debug,
  input  logic            remap,
  input  logic [XLEN-1:0] base_n,
  input  logic [XLEN-1:0] base_d,
  output logic [XLEN-1:0] vec
);
  logic [XLEN-1:0] base;
  logic [XLEN-1:0] offs;

  assign base = (is_debug || remap) ? base_d : base_n;
  assign offs = XLEN'(cause) << SHIFT;
  assign vec  = base + offs;
endmodule

// File: rtl/exc_ie_update.sv
module exc_ie_update
  import exc_entry_pkg::*;
(
  input  kind_e              kind,
  input  logic [IEREG_W-1:0] ie_cur,
  output logic [IEREG_W-1:0] ie_new,
  output logic               to_ea,
  output logic               to_ba
);
  always_comb begin
    ie_new = ie_cur;
    to_ea  = 1'b0;
    to_ba  = 1'b0;
    ie_new[IE_BIT] = 1'b0;
    case (kind)
      K_RESET: begin
        ie_new = '0;
      end
      K_DEBUG: begin
        to_ba = 1'b1;
        ie_new[BIE_BIT] = ie_cur[BIE_BIT] | ie_cur[IE_BIT];
      end
      default: begin
        to_ea = 1'b1;
        ie_new[EIE_BIT] = ie_cur[EIE_BIT] | ie_cur[IE_BIT];
      end
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [CAUSE_N-1:0]  req_pend,
  input  logic [XLEN-1:0]     req_pc,
  input  logic [IEREG_W-1:0]  req_ie,
  input  logic [XLEN-1:0]     norm_base,
  input  logic [XLEN-1:0]     dbg_base,
  input  logic                dbg_remap,
  output logic                redir_valid,
  input  logic                redir_ready,
  output logic [XLEN-1:0]     redir_pc,
  output logic                save_ea,
  output logic                save_ba,
  output logic [XLEN-1:0]     save_pc,
  output logic [IEREG_W-1:0]  ie_next
);
  logic               sel_any;
  logic [CAUSE_W-1:0] sel_idx;
  kind_e              sel_kind;
  logic [XLEN-1:0]    sel_vec;
  logic [IEREG_W-1:0] sel_ie;
  logic               sel_ea;
  logic               sel_ba;
  logic               take;
  logic               load;

  exc_cause_arb #(.N(CAUSE_N), .IRQ(IRQ_IDX)) u_arb (
    .pend   (req_pend),
    .irq_en (req_ie[IE_BIT]),
    .any    (sel_any),
    .idx    (sel_idx)
  );

  assign sel_kind = kind_of(sel_idx);

  exc_vector_gen #(.XLEN(XLEN), .CW(CAUSE_W), .SHIFT(VEC_SHIFT)) u_vec (
    .cause    (sel_idx),
    .is_debug (sel_kind == K_DEBUG),
    .remap    (dbg_remap),
    .base_n   (norm_base),
    .base_d   (dbg_base),
    .vec      (sel_vec)
  );

  exc_ie_update u_ie (
    .kind   (sel_kind),
    .ie_cur (req_ie),
    .ie_new (sel_ie),
    .to_ea  (sel_ea),
    .to_ba  (sel_ba)
  );

  assign req_ready = !redir_valid || redir_ready;
  assign take      = req_valid && req_ready;
  assign load      = take && sel_any;

  logic               r_valid;
  logic [XLEN-1:0]    r_vec;
  logic               r_ea;
  logic               r_ba;
  logic [XLEN-1:0]    r_pc;
  logic [IEREG_W-1:0] r_ie;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_vec   <= '0;
      r_ea    <= 1'b0;
      r_ba    <= 1'b0;
      r_pc    <= '0;
      r_ie    <= '0;
    end else begin
      if (load) begin
        r_valid <= 1'b1;
        r_vec   <= sel_vec;
        r_ea    <= sel_ea;
        r_ba    <= sel_ba;
        r_pc    <= req_pc;
        r_ie    <= sel_ie;
      end else if (redir_ready) begin
        r_valid <= 1'b0;
      end
    end
  end

  assign redir_valid = r_valid;
  assign redir_pc    = r_vec;
  assign save_ea     = r_valid & r_ea;
  assign save_ba     = r_valid & r_ba;
  assign save_pc     = r_pc;
  assign ie_next     = r_ie;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [7:0]      req_pend,
  input logic [XLEN-1:0] req_pc,
  input logic [2:0]      req_ie,
  input logic            redir_valid,
  input logic            redir_ready,
  input logic [XLEN-1:0] redir_pc,
  input logic            save_ea,
  input logic            save_ba,
  input logic [XLEN-1:0] save_pc,
  input logic [2:0]      ie_next
);
  // R9: held beat blocks new requests
  p_block_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_ready) |-> !req_ready);

  // R9: held beat keeps its fields
  p_hold_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && !redir_ready) |=> (redir_valid && $stable(redir_pc)
      && $stable(save_pc) && $stable(ie_next) && $stable(save_ea) && $stable(save_ba)));

  // R5/R6: at most one link written per beat
  p_one_link_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_ea, save_ba}));

  // R6: IE is always cleared on entry
  p_ie_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> !ie_next[0]);

  // R2: a lone masked interrupt produces no beat
  p_irq_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_ie[0] && req_pend == 8'h40) |=> !redir_valid);

  // R8: accepted request with a live cause yields a beat carrying its PC
  p_beat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_pend & 8'hBF) != 8'h00) |=> (redir_valid && save_pc == $past(req_pc)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_pend;
  logic [31:0] req_pc;
  logic [2:0]  req_ie;
  logic [31:0] norm_base;
  logic [31:0] dbg_base;
  logic        dbg_remap;
  logic        redir_valid;
  logic        redir_ready;
  logic [31:0] redir_pc;
  logic        save_ea;
  logic        save_ba;
  logic [31:0] save_pc;
  logic [2:0]  ie_next;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  exc_entry_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_pend(req_pend), .req_pc(req_pc), .req_ie(req_ie),
    .norm_base(norm_base), .dbg_base(dbg_base), .dbg_remap(dbg_remap),
    .redir_valid(redir_valid), .redir_ready(redir_ready), .redir_pc(redir_pc),
    .save_ea(save_ea), .save_ba(save_ba), .save_pc(save_pc), .ie_next(ie_next)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int pick(input logic [7:0] p, input logic ie0);
    for (int i = 0; i < 8; i++) begin
      if (p[i] && (i != 6 || ie0)) return i;
    end
    return -1;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    rst_n = 1'b0; req_valid = 1'b0; req_pend = '0; req_pc = '0; req_ie = '0;
    norm_base = '0; dbg_base = '0; dbg_remap = 1'b0; redir_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(redir_valid == 1'b0, "R10 valid after reset", 32'(redir_valid), 0);
    chk(req_ready == 1'b1, "R10 ready after reset", 32'(req_ready), 1);
    rst_n = 1'b1;

    n = 0;
    for (int rm = 0; rm < 2; rm++) begin
      for (int ie = 0; ie < 8; ie++) begin
        for (int p = 0; p < 256; p++) begin
          int c;
          logic [31:0] base, ev;
          logic [2:0]  eie;
          bit dbg;
          n++;
          chk(req_ready == 1'b1, "R9 ready when output drains", 32'(req_ready), 1);
          req_valid = 1'b1;
          req_pend  = 8'(p);
          req_ie    = 3'(ie);
          dbg_remap = rm[0];
          norm_base = 32'h1000_0000 + 32'(n) * 32'h100;
          dbg_base  = 32'h8000_0000 - 32'(n) * 32'h40;
          req_pc    = 32'h0000_4000 + 32'(n) * 4;
          c   = pick(8'(p), ie[0]);
          dbg = (c == 1 || c == 3);
          @(negedge clk);
          if (c < 0) begin
            chk(redir_valid == 1'b0, "R2/R8 no live cause gives no beat", 32'(redir_valid), 0);
          end else begin
            chk(redir_valid == 1'b1, "R1/R8 beat follows accepted request", 32'(redir_valid), 1);
            base = (dbg || rm == 1) ? dbg_base : norm_base;
            ev   = base + 32'(c) * 32;
            chk(redir_pc == ev, dbg ? "R1/R3 debug vector" : "R1/R2/R4 normal vector", redir_pc, ev);
            if (c == 0) begin
              chk(!save_ea && !save_ba, "R7 no link on reset cause", {30'd0, save_ea, save_ba}, 0);
              chk(ie_next == 3'd0, "R7 enables cleared", 32'(ie_next), 0);
            end else if (dbg) begin
              eie = {ie[2] | ie[0], ie[1], 1'b0};
              chk(save_ba && !save_ea, "R6 breakpoint link", {30'd0, save_ea, save_ba}, 1);
              chk(save_pc == req_pc, "R6 saved pc", save_pc, req_pc);
              chk(ie_next == eie, "R6 enable update", 32'(ie_next), 32'(eie));
            end else begin
              eie = {ie[2], ie[1] | ie[0], 1'b0};
              chk(save_ea && !save_ba, "R5 exception link", {30'd0, save_ea, save_ba}, 2);
              chk(save_pc == req_pc, "R5 saved pc", save_pc, req_pc);
              chk(ie_next == eie, "R5 enable update", 32'(ie_next), 32'(eie));
            end
          end
        end
      end
    end

    // back-pressure sequence
    req_valid = 1'b0;
    @(negedge clk);
    chk(redir_valid == 1'b0, "R8 idle after drain", 32'(redir_valid), 0);
    norm_base = 32'h0002_0000; dbg_base = 32'h0009_0000; dbg_remap = 1'b0;
    req_ie = 3'b001; req_pc = 32'h0000_1234; req_pend = 8'h04;
    redir_ready = 1'b0; req_valid = 1'b1;
    @(negedge clk);
    chk(redir_valid == 1'b1, "R9 beat raised under stall", 32'(redir_valid), 1);
    chk(req_ready == 1'b0, "R9 request blocked", 32'(req_ready), 0);
    req_pend = 8'h02; req_pc = 32'h0000_5678;
    repeat (3) @(negedge clk);
    chk(redir_pc == 32'h0002_0040, "R9 vector held", redir_pc, 32'h0002_0040);
    chk(save_pc == 32'h0000_1234, "R9 saved pc held", save_pc, 32'h0000_1234);
    chk(save_ea == 1'b1, "R9 link select held", 32'(save_ea), 1);
    redir_ready = 1'b1;
    @(negedge clk);
    chk(redir_pc == 32'h0009_0020, "R9/R3 next request after release", redir_pc, 32'h0009_0020);
    chk(save_pc == 32'h0000_5678, "R9/R6 next saved pc", save_pc, 32'h0000_5678);
    req_valid = 1'b0;
    @(negedge clk);
    chk(redir_valid == 1'b0, "R8 beat consumed", 32'(redir_valid), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule